// File: doc/BRIEF.md
# Writeback-Allocating Cache Access Controller

This block holds the lookup, permission and victim-allocation logic for a small set-associative cache that sits below another cache. The upper cache sends shared reads, exclusive reads, stores, store-conditionals and whole-line writebacks. A refill completion also arrives on the same request port. Each request is classified in the cycle it is accepted. It can be satisfied, absorbed, failed or reported as a miss, and the verdict appears on a registered response one cycle later.

A writeback that finds no copy of its line is not sent further down. The controller claims a frame in the set for it. The frame is the one the set's round-robin pointer selects. The controller first asks the outstanding-miss table, through a probe address and a match input, whether that frame's current line has a pending upgrade. If it does, the frame cannot be replaced and the writeback is refused. If the frame holds dirty data, that data leaves through a valid/ready write-buffer port, stamped with a ready time. Until the buffer can take it, the request is held off. A writeback that finds a read-only copy updates the data and the dirty bit, and grants no write permission.

Top module: `wbc_top`

## Requirements
- R1: Command codes on `reqCmd` are 0 shared read, 1 exclusive read, 2 store, 3 store-conditional, 4 writeback and 5 refill. The line address is split with set = `reqAddr[1:0]` and tag = the remaining upper bits. Codes 1, 2 and 3 hit only on a present, writable line. Codes 0 and 4 hit on any present line. A hit is reported as handled and counted as a hit. Reads return the line on `respData`, which is zero otherwise. A store or store-conditional hit overwrites the line and marks it dirty.
- R2: A writeback that finds its line present overwrites the whole line and marks it dirty, and leaves the writable bit as it was. It is handled and counted as a hit.
- R3: A writeback whose line is absent takes the frame named by the set's pointer. It installs the line there as valid, dirty and not writable, and is handled and counted as a hit.
- R4: If the chosen frame is valid and `mshrMatch` is high for the probe address (victim tag and set), allocation fails. A writeback is then counted as a miss and is not handled. No frame, pointer or write-buffer output changes.
- R5: A valid, dirty victim of a successful allocation is offered on the write-buffer port with its line address and data. Its ready time is the current cycle count plus HIT_LAT. The cycle count is zero in the first cycle after reset and then rises by one per clock.
- R6: While a victim writeback is pending and `wbReady` is low, `reqReady` is low and nothing is committed.
- R7: Each set's pointer starts at way 0 after reset. It advances by one, wrapping at the way count, only when an allocation commits.
- R8: A store-conditional with no copy of its line is handled, counted as a miss, and returns `respScOk` = 0. A store-conditional hit returns 1.
- R9: Any other request that is not satisfied and is not a writeback or refill is counted as a miss and is not handled.
- R10: A refill to a present line sets the writable bit to `reqWritable` and leaves the data alone. A refill to an absent line allocates as in R3 to R5, and installs the line clean with writability from `reqWritable`. A refill counts as neither hit nor miss, and it is handled unless allocation fails.
- R11: The response is valid for exactly the one cycle after acceptance. After reset all lines are invalid and `respValid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Request accepted this cycle when high with reqValid |
| reqCmd | input | 3 | Command code (R1) |
| reqAddr | input | ADDR_W | Line address |
| reqData | input | LINE_W | Full line for stores, writebacks, refills |
| reqWritable | input | 1 | Refill permission |
| mshrProbeAddr | output | ADDR_W | Line address of the chosen victim |
| mshrMatch | input | 1 | Outstanding upgrade exists for the probe address |
| wbValid | output | 1 | Victim writeback offered |
| wbReady | input | 1 | Write buffer can accept |
| wbAddr | output | ADDR_W | Victim line address |
| wbData | output | LINE_W | Victim line data |
| wbReadyTime | output | TIME_W | Cycle when the writeback may issue |
| respValid | output | 1 | Response strobe |
| respHandled | output | 1 | Request handled here |
| respHit | output | 1 | Counted as a hit |
| respMiss | output | 1 | Counted as a miss |
| respScOk | output | 1 | Store-conditional result |
| respData | output | LINE_W | Read data |

## Verification
The hardest case to reach is allocation that is blocked by a pending upgrade on the victim frame. It needs a valid line sitting under that set's pointer, a modelled miss-table entry for exactly that line, and a check afterwards that neither the frame nor the pointer moved. The bench fills a set through writebacks and refills until the pointer wraps onto a dirty line. It then raises a match for that line's address, shows that the line still reads back, and clears the match. The retried writeback must then evict that same line, which shows the pointer stayed put. The stall is reached by holding the write buffer not-ready for several cycles while a dirty eviction waits.

// File: rtl/wbc_pkg.sv
package wbc_pkg;

  typedef enum logic [2:0] {
    CMD_RD   = 3'd0,
    CMD_RDX  = 3'd1,
    CMD_WR   = 3'd2,
    CMD_SC   = 3'd3,
    CMD_WB   = 3'd4,
    CMD_FILL = 3'd5
  } cmd_e;

  // strobes from control to datapath, applied on commit
  typedef struct packed {
    logic dataWe;
    logic tagWe;
    logic setValid;
    logic setDirty;
    logic clrDirty;
    logic setWritable;
    logic clrWritable;
    logic rrAdvance;
  } strobe_t;

endpackage

// File: rtl/wbc_datapath.sv
module wbc_datapath
  import wbc_pkg::*;
#(
  parameter int SETS    = 4,
  parameter int WAYS    = 2,
  parameter int ADDR_W  = 8,
  parameter int LINE_W  = 32,
  parameter int TIME_W  = 16,
  parameter int WAY_W   = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [LINE_W-1:0] reqData,
  input  logic              commit,
  input  strobe_t           strb,
  input  logic [WAY_W-1:0]  strbWay,
  output logic              present,
  output logic [WAY_W-1:0]  presentWay,
  output logic              presentWritable,
  output logic [LINE_W-1:0] presentData,
  output logic [WAY_W-1:0]  victimWay,
  output logic              victimValid,
  output logic              victimDirty,
  output logic [ADDR_W-1:0] victimAddr,
  output logic [LINE_W-1:0] victimData,
  output logic [TIME_W-1:0] nowTime
);

  localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1;
  localparam int TAG_W = ADDR_W - SET_W;

  logic [TAG_W-1:0]  tagQ  [SETS][WAYS];
  logic [LINE_W-1:0] dataQ [SETS][WAYS];
  logic [WAYS-1:0]   validQ [SETS];
  logic [WAYS-1:0]   dirtyQ [SETS];
  logic [WAYS-1:0]   writQ  [SETS];
  logic [WAY_W-1:0]  rrQ    [SETS];
  logic [TIME_W-1:0] nowQ;

  logic [SET_W-1:0] setIdx;
  logic [TAG_W-1:0] reqTag;
  logic [WAYS-1:0]  wayHit;

  assign setIdx = reqAddr[SET_W-1:0];
  assign reqTag = reqAddr[ADDR_W-1:SET_W];

  generate
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
      assign wayHit[w] = validQ[setIdx][w] && (tagQ[setIdx][w] == reqTag);
    end
  endgenerate

  always_comb begin
    presentWay = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (wayHit[w]) presentWay = WAY_W'(w);
    end
  end

  assign present         = |wayHit;
  assign presentWritable = writQ[setIdx][presentWay];
  assign presentData     = dataQ[setIdx][presentWay];

  assign victimWay   = rrQ[setIdx];
  assign victimValid = validQ[setIdx][victimWay];
  assign victimDirty = dirtyQ[setIdx][victimWay];
  assign victimAddr  = {tagQ[setIdx][victimWay], setIdx};
  assign victimData  = dataQ[setIdx][victimWay];
  assign nowTime     = nowQ;

  // payload arrays: no reset needed, guarded by valid bits
  always_ff @(posedge clk) begin
    if (commit && strb.tagWe)  tagQ[setIdx][strbWay]  <= reqTag;
    if (commit && strb.dataWe) dataQ[setIdx][strbWay] <= reqData;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        validQ[s] <= '0;
        dirtyQ[s] <= '0;
        writQ[s]  <= '0;
        rrQ[s]    <= '0;
      end
      nowQ <= '0;
    end else begin
      nowQ <= nowQ + 1'b1;
      if (commit) begin
        if (strb.setValid)    validQ[setIdx][strbWay] <= 1'b1;
        if (strb.setDirty)    dirtyQ[setIdx][strbWay] <= 1'b1;
        if (strb.clrDirty)    dirtyQ[setIdx][strbWay] <= 1'b0;
        if (strb.setWritable) writQ[setIdx][strbWay]  <= 1'b1;
        if (strb.clrWritable) writQ[setIdx][strbWay]  <= 1'b0;
        if (strb.rrAdvance) begin
          if (rrQ[setIdx] == WAY_W'(WAYS - 1)) rrQ[setIdx] <= '0;
          else                                 rrQ[setIdx] <= rrQ[setIdx] + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/wbc_control.sv
module wbc_control
  import wbc_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int LINE_W  = 32,
  parameter int TIME_W  = 16,
  parameter int HIT_LAT = 3,
  parameter int WAY_W   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [2:0]        reqCmd,
  input  logic              reqWritable,
  input  logic              present,
  input  logic [WAY_W-1:0]  presentWay,
  input  logic              presentWritable,
  input  logic [LINE_W-1:0] presentData,
  input  logic [WAY_W-1:0]  victimWay,
  input  logic              victimValid,
  input  logic              victimDirty,
  input  logic [ADDR_W-1:0] victimAddr,
  input  logic [LINE_W-1:0] victimData,
  input  logic [TIME_W-1:0] nowTime,
  input  logic              mshrMatch,
  input  logic              wbReady,
  output logic              wbValid,
  output logic [ADDR_W-1:0] wbAddr,
  output logic [LINE_W-1:0] wbData,
  output logic [TIME_W-1:0] wbReadyTime,
  output logic              commit,
  output strobe_t           strb,
  output logic [WAY_W-1:0]  strbWay,
  output logic              respValid,
  output logic              respHandled,
  output logic              respHit,
  output logic              respMiss,
  output logic              respScOk,
  output logic [LINE_W-1:0] respData
);

  cmd_e cmd;
  logic isRead, needExcl, satisfied, needAlloc, allocOk, needWb;
  logic vHandled, vHit, vMiss, vScOk;

  assign cmd      = cmd_e'(reqCmd);
  assign isRead   = (cmd == CMD_RD) || (cmd == CMD_RDX);
  assign needExcl = (cmd == CMD_RDX) || (cmd == CMD_WR) || (cmd == CMD_SC);

  assign satisfied = present && (cmd != CMD_FILL) && (!needExcl || presentWritable);
  assign needAlloc = !present && ((cmd == CMD_WB) || (cmd == CMD_FILL));
  assign allocOk   = needAlloc && !(victimValid && mshrMatch);
  assign needWb    = allocOk && victimValid && victimDirty;

  assign wbValid     = reqValid && needWb;
  assign wbAddr      = victimAddr;
  assign wbData      = victimData;
  assign wbReadyTime = nowTime + TIME_W'(HIT_LAT);

  assign reqReady = !wbValid || wbReady;
  assign commit   = reqValid && reqReady;
  assign strbWay  = present ? presentWay : victimWay;

  always_comb begin
    strb = '0;
    unique case (cmd)
      CMD_WR, CMD_SC: begin
        if (satisfied) begin
          strb.dataWe   = 1'b1;
          strb.setDirty = 1'b1;
        end
      end
      CMD_WB: begin
        if (present) begin
          strb.dataWe   = 1'b1;
          strb.setDirty = 1'b1;
        end else if (allocOk) begin
          strb.tagWe       = 1'b1;
          strb.dataWe      = 1'b1;
          strb.setValid    = 1'b1;
          strb.setDirty    = 1'b1;
          strb.clrWritable = 1'b1;
          strb.rrAdvance   = 1'b1;
        end
      end
      CMD_FILL: begin
        if (present) begin
          strb.setWritable = reqWritable;
          strb.clrWritable = !reqWritable;
        end else if (allocOk) begin
          strb.tagWe       = 1'b1;
          strb.dataWe      = 1'b1;
          strb.setValid    = 1'b1;
          strb.clrDirty    = 1'b1;
          strb.setWritable = reqWritable;
          strb.clrWritable = !reqWritable;
          strb.rrAdvance   = 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_comb begin
    vHit     = satisfied || ((cmd == CMD_WB) && allocOk);
    vMiss    = (cmd != CMD_FILL) && !vHit;
    vScOk    = (cmd == CMD_SC) && satisfied;
    vHandled = satisfied
             || (((cmd == CMD_WB) || (cmd == CMD_FILL)) && (present || allocOk))
             || ((cmd == CMD_SC) && !present);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      respValid   <= 1'b0;
      respHandled <= 1'b0;
      respHit     <= 1'b0;
      respMiss    <= 1'b0;
      respScOk    <= 1'b0;
      respData    <= '0;
    end else begin
      respValid   <= commit;
      respHandled <= commit && vHandled;
      respHit     <= commit && vHit;
      respMiss    <= commit && vMiss;
      respScOk    <= commit && vScOk;
      respData    <= (commit && isRead && satisfied) ? presentData : '0;
    end
  end

endmodule

// File: rtl/wbc_top.sv
module wbc_top
  import wbc_pkg::*;
#(
  parameter int SETS    = 4,
  parameter int WAYS    = 2,
  parameter int ADDR_W  = 8,
  parameter int LINE_W  = 32,
  parameter int TIME_W  = 16,
  parameter int HIT_LAT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [2:0]        reqCmd,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [LINE_W-1:0] reqData,
  input  logic              reqWritable,
  output logic [ADDR_W-1:0] mshrProbeAddr,
  input  logic              mshrMatch,
  output logic              wbValid,
  input  logic              wbReady,
  output logic [ADDR_W-1:0] wbAddr,
  output logic [LINE_W-1:0] wbData,
  output logic [TIME_W-1:0] wbReadyTime,
  output logic              respValid,
  output logic              respHandled,
  output logic              respHit,
  output logic              respMiss,
  output logic              respScOk,
  output logic [LINE_W-1:0] respData
);

  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

  logic              present, presentWritable, victimValid, victimDirty, commit;
  logic [WAY_W-1:0]  presentWay, victimWay, strbWay;
  logic [LINE_W-1:0] presentData, victimData;
  logic [ADDR_W-1:0] victimAddr;
  logic [TIME_W-1:0] nowTime;
  strobe_t           strb;

  assign mshrProbeAddr = victimAddr;

  wbc_datapath #(
    .SETS(SETS), .WAYS(WAYS), .ADDR_W(ADDR_W), .LINE_W(LINE_W),
    .TIME_W(TIME_W), .WAY_W(WAY_W)
  ) dp_i (
    .clk(clk), .rst_n(rst_n), .reqAddr(reqAddr), .reqData(reqData),
    .commit(commit), .strb(strb), .strbWay(strbWay),
    .present(present), .presentWay(presentWay),
    .presentWritable(presentWritable), .presentData(presentData),
    .victimWay(victimWay), .victimValid(victimValid),
    .victimDirty(victimDirty), .victimAddr(victimAddr),
    .victimData(victimData), .nowTime(nowTime)
  );

  wbc_control #(
    .ADDR_W(ADDR_W), .LINE_W(LINE_W), .TIME_W(TIME_W),
    .HIT_LAT(HIT_LAT), .WAY_W(WAY_W)
  ) ctl_i (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqReady(reqReady),
    .reqCmd(reqCmd), .reqWritable(reqWritable),
    .present(present), .presentWay(presentWay),
    .presentWritable(presentWritable), .presentData(presentData),
    .victimWay(victimWay), .victimValid(victimValid),
    .victimDirty(victimDirty), .victimAddr(victimAddr),
    .victimData(victimData), .nowTime(nowTime),
    .mshrMatch(mshrMatch), .wbReady(wbReady), .wbValid(wbValid),
    .wbAddr(wbAddr), .wbData(wbData), .wbReadyTime(wbReadyTime),
    .commit(commit), .strb(strb), .strbWay(strbWay),
    .respValid(respValid), .respHandled(respHandled), .respHit(respHit),
    .respMiss(respMiss), .respScOk(respScOk), .respData(respData)
  );

endmodule

// File: rtl/wbc_checker.sv
module wbc_checker #(
  parameter int TIME_W  = 16,
  parameter int HIT_LAT = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reqValid,
  input logic              reqReady,
  input logic              mshrMatch,
  input logic              wbValid,
  input logic              wbReady,
  input logic [TIME_W-1:0] wbReadyTime,
  input logic              respValid,
  input logic              respHandled,
  input logic              respHit,
  input logic              respMiss,
  input logic              respScOk
);

  logic [TIME_W-1:0] cycChk;
  logic              acceptQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cycChk  <= '0;
      acceptQ <= 1'b0;
    end else begin
      cycChk  <= cycChk + 1'b1;
      acceptQ <= reqValid && reqReady;
    end
  end

  assert_resp_one_cycle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    respValid == acceptQ);

  assert_stall_on_buffer_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wbValid && !wbReady) |-> !reqReady);

  assert_ready_time_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wbValid |-> (wbReadyTime == cycChk + TIME_W'(HIT_LAT)));

  assert_no_evict_pending_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wbValid |-> !mshrMatch);

  assert_sc_ok_is_hit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    respScOk |-> (respHandled && respHit));

  assert_hit_miss_apart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(respHit && respMiss));

endmodule

bind wbc_top wbc_checker #(.TIME_W(TIME_W), .HIT_LAT(HIT_LAT)) chk_i (
  .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqReady(reqReady),
  .mshrMatch(mshrMatch), .wbValid(wbValid), .wbReady(wbReady),
  .wbReadyTime(wbReadyTime), .respValid(respValid),
  .respHandled(respHandled), .respHit(respHit), .respMiss(respMiss),
  .respScOk(respScOk)
);

// File: tb/wbc_tb.sv
module wbc_top_tb_top;

  localparam int HIT_LAT = 3;

  typedef struct packed {
    logic [2:0]  cmd;
    logic [7:0]  addr;
    logic [31:0] data;
    logic        writ;
    logic        handled;
    logic        hit;
    logic        miss;
    logic        scOk;
    logic        wb;
    logic [7:0]  wbAddr;
    logic [31:0] wbData;
    logic [31:0] rdData;
  } vec_t;

  // set = addr[1:0]; 05,09,0D all map to set 1 with tags 1,2,3
  localparam vec_t VECS [16] = '{
    '{3'd0, 8'h05, 32'h0,        1'b0, 1'b0,1'b0,1'b1,1'b0,1'b0, 8'h00, 32'h0, 32'h0},        // R9 read miss
    '{3'd4, 8'h05, 32'h11111111, 1'b0, 1'b1,1'b1,1'b0,1'b0,1'b0, 8'h00, 32'h0, 32'h0},        // R3 alloc way0
    '{3'd0, 8'h05, 32'h0,        1'b0, 1'b1,1'b1,1'b0,1'b0,1'b0, 8'h00, 32'h0, 32'h11111111}, // R1
    '{3'd2, 8'h05, 32'h22222222, 1'b0, 1'b0,1'b0,1'b1,1'b0,1'b0, 8'h00, 32'h0, 32'h0},        // R1 not writable
    '{3'd1, 8'h05, 32'h0,        1'b0, 1'b0,1'b0,1'b1,1'b0,1'b0, 8'h00, 32'h0, 32'h0},        // R9
    '{3'd4, 8'h05, 32'h33333333, 1'b0, 1'b1,1'b1,1'b0,1'b0,1'b0, 8'h00, 32'h0, 32'h0},        // R2
    '{3'd0, 8'h05, 32'h0,        1'b0, 1'b1,1'b1,1'b0,1'b0,1'b0, 8'h00, 32'h0, 32'h33333333}, // R2
    '{3'd5, 8'h09, 32'h44444444, 1'b1, 1'b1,1'b0,1'b0,1'b0,1'b0, 8'h00, 32'h0, 32'h0},        // R10 alloc way1
    '{3'd2, 8'h09, 32'h55555555, 1'b0, 1'b1,1'b1,1'b0,1'b0,1'b0, 8'h00, 32'h0, 32'h0},        // R1
    '{3'd1, 8'h09, 32'h0,        1'b0, 1'b1,1'b1,1'b0,1'b0,1'b0, 8'h00, 32'h0, 32'h55555555}, // R1
    '{3'd3, 8'h09, 32'h66666666, 1'b0, 1'b1,1'b1,1'b0,1'b1,1'b0, 8'h00, 32'h0, 32'h0},        // R8 hit
    '{3'd3, 8'h0D, 32'h0,        1'b0, 1'b1,1'b0,1'b1,1'b0,1'b0, 8'h00, 32'h0, 32'h0},        // R8 miss
    '{3'd0, 8'h0D, 32'h0,        1'b0, 1'b0,1'b0,1'b1,1'b0,1'b0, 8'h00, 32'h0, 32'h0},        // R9
    '{3'd4, 8'h0D, 32'h77777777, 1'b0, 1'b1,1'b1,1'b0,1'b0,1'b1, 8'h05, 32'h33333333, 32'h0}, // R5 R7
    '{3'd0, 8'h05, 32'h0,        1'b0, 1'b0,1'b0,1'b1,1'b0,1'b0, 8'h00, 32'h0, 32'h0},        // R3 evicted
    '{3'd0, 8'h0D, 32'h0,        1'b0, 1'b1,1'b1,1'b0,1'b0,1'b0, 8'h00, 32'h0, 32'h77777777}  // R3
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [2:0]  reqCmd = '0;
  logic [7:0]  reqAddr = '0;
  logic [31:0] reqData = '0;
  logic        reqWritable = 1'b0;
  logic [7:0]  mshrProbeAddr;
  logic        mshrMatch;
  logic        wbValid;
  logic        wbReady = 1'b1;
  logic [7:0]  wbAddr;
  logic [31:0] wbData;
  logic [15:0] wbReadyTime;
  logic        respValid, respHandled, respHit, respMiss, respScOk;
  logic [31:0] respData;

  logic        pendValid = 1'b0;
  logic [7:0]  pendAddr = '0;
  assign mshrMatch = pendValid && (mshrProbeAddr == pendAddr);

  always #4 clk = ~clk;

  wbc_top #(.HIT_LAT(HIT_LAT)) dut_i (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqReady(reqReady),
    .reqCmd(reqCmd), .reqAddr(reqAddr), .reqData(reqData),
    .reqWritable(reqWritable), .mshrProbeAddr(mshrProbeAddr),
    .mshrMatch(mshrMatch), .wbValid(wbValid), .wbReady(wbReady),
    .wbAddr(wbAddr), .wbData(wbData), .wbReadyTime(wbReadyTime),
    .respValid(respValid), .respHandled(respHandled), .respHit(respHit),
    .respMiss(respMiss), .respScOk(respScOk), .respData(respData)
  );

  int unsigned cyc;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  int nChecks = 0;
  int nFail = 0;
  bit finished = 0;

  logic        gWbV;
  logic [7:0]  gWbA;
  logic [31:0] gWbD;
  logic [15:0] gWbT;
  int unsigned gCyc;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // called just after a negedge; returns just after a later negedge with the response visible
  task automatic issue(input logic [2:0] c, input logic [7:0] a,
                       input logic [31:0] d, input logic w);
    reqCmd = c; reqAddr = a; reqData = d; reqWritable = w; reqValid = 1'b1;
    #1;
    for (int g = 0; g < 50 && !reqReady; g++) begin
      @(negedge clk); #1;
    end
    gWbV = wbValid; gWbA = wbAddr; gWbD = wbData; gWbT = wbReadyTime; gCyc = cyc;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    #1;
  endtask

  task automatic expResp(input string tag, input logic h, input logic hi, input logic m,
                         input logic [31:0] rd);
    chk({tag, " respValid R11"}, {31'b0, respValid}, 32'd1);
    chk({tag, " handled"}, {31'b0, respHandled}, {31'b0, h});
    chk({tag, " hit"}, {31'b0, respHit}, {31'b0, hi});
    chk({tag, " miss"}, {31'b0, respMiss}, {31'b0, m});
    chk({tag, " data"}, respData, rd);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    // R11 reset state
    chk("R11 reset respValid", {31'b0, respValid}, 32'd0);
    chk("R11 reset reqReady", {31'b0, reqReady}, 32'd1);
    rst_n = 1'b1;
    @(negedge clk); #1;

    for (int i = 0; i < 16; i++) begin
      issue(VECS[i].cmd, VECS[i].addr, VECS[i].data, VECS[i].writ);
      chk($sformatf("R11 vec%0d respValid", i), {31'b0, respValid}, 32'd1);
      chk($sformatf("R1 vec%0d handled", i), {31'b0, respHandled}, {31'b0, VECS[i].handled});
      chk($sformatf("R1 vec%0d hit", i), {31'b0, respHit}, {31'b0, VECS[i].hit});
      chk($sformatf("R9 vec%0d miss", i), {31'b0, respMiss}, {31'b0, VECS[i].miss});
      chk($sformatf("R8 vec%0d scOk", i), {31'b0, respScOk}, {31'b0, VECS[i].scOk});
      chk($sformatf("R1 vec%0d data", i), respData, VECS[i].rdData);
      chk($sformatf("R5 vec%0d wbValid", i), {31'b0, gWbV}, {31'b0, VECS[i].wb});
      if (VECS[i].wb) begin
        chk($sformatf("R5 vec%0d wbAddr", i), {24'b0, gWbA}, {24'b0, VECS[i].wbAddr});
        chk($sformatf("R5 vec%0d wbData", i), gWbD, VECS[i].wbData);
        chk($sformatf("R5 vec%0d readyTime", i), {16'b0, gWbT}, gCyc + HIT_LAT);
      end
    end
    @(negedge clk); #1;
    chk("R11 single-cycle response", {31'b0, respValid}, 32'd0);

    // R6: stall while the write buffer is full; victim is way1 = 09 (dirty 66666666)
    wbReady = 1'b0;
    reqCmd = 3'd4; reqAddr = 8'h11; reqData = 32'h99999999; reqWritable = 1'b0; reqValid = 1'b1;
    #1;
    chk("R6 wbValid while stalled", {31'b0, wbValid}, 32'd1);
    chk("R6 reqReady low", {31'b0, reqReady}, 32'd0);
    repeat (3) @(negedge clk);
    #1;
    chk("R6 no response while stalled", {31'b0, respValid}, 32'd0);
    chk("R6 still stalled", {31'b0, reqReady}, 32'd0);
    wbReady = 1'b1;
    issue(3'd4, 8'h11, 32'h99999999, 1'b0);
    chk("R6 victim addr", {24'b0, gWbA}, 32'h09);
    chk("R6 victim data", gWbD, 32'h66666666);
    chk("R5 ready time after stall", {16'b0, gWbT}, gCyc + HIT_LAT);
    expResp("R6 accepted", 1'b1, 1'b1, 1'b0, 32'h0);

    // R4: pointer of set 1 is back on way0 = 0D; pending upgrade blocks it
    pendValid = 1'b1; pendAddr = 8'h0D;
    issue(3'd4, 8'h15, 32'h88888888, 1'b0);
    chk("R4 no writeback", {31'b0, gWbV}, 32'd0);
    expResp("R4 blocked", 1'b0, 1'b0, 1'b1, 32'h0);
    issue(3'd0, 8'h0D, 32'h0, 1'b0);
    expResp("R4 line kept", 1'b1, 1'b1, 1'b0, 32'h77777777);
    pendValid = 1'b0;
    issue(3'd4, 8'h15, 32'h88888888, 1'b0);
    chk("R7 pointer held on failure", {24'b0, gWbA}, 32'h0D);
    chk("R7 wbValid", {31'b0, gWbV}, 32'd1);
    expResp("R3 retry", 1'b1, 1'b1, 1'b0, 32'h0);
    issue(3'd0, 8'h11, 32'h0, 1'b0);
    expResp("R3 other way kept", 1'b1, 1'b1, 1'b0, 32'h99999999);

    // R4: match on an invalid victim is ignored (set 2)
    pendValid = 1'b1; pendAddr = 8'h02;
    issue(3'd4, 8'h06, 32'hAAAAAAAA, 1'b0);
    expResp("R4 invalid victim", 1'b1, 1'b1, 1'b0, 32'h0);
    pendValid = 1'b0;

    // R10: refill grants and revokes write permission without touching data
    issue(3'd2, 8'h06, 32'h12121212, 1'b0);
    expResp("R2 wb no write grant", 1'b0, 1'b0, 1'b1, 32'h0);
    issue(3'd5, 8'h06, 32'hBBBBBBBB, 1'b1);
    expResp("R10 fill present", 1'b1, 1'b0, 1'b0, 32'h0);
    issue(3'd2, 8'h06, 32'hCCCCCCCC, 1'b0);
    expResp("R10 write after grant", 1'b1, 1'b1, 1'b0, 32'h0);
    issue(3'd0, 8'h06, 32'h0, 1'b0);
    expResp("R10 data not from fill", 1'b1, 1'b1, 1'b0, 32'hCCCCCCCC);
    issue(3'd5, 8'h06, 32'h0, 1'b0);
    issue(3'd1, 8'h06, 32'h0, 1'b0);
    expResp("R10 revoked", 1'b0, 1'b0, 1'b1, 32'h0);

    // R10 clean fill allocation, then eviction of dirty then clean line
    issue(3'd5, 8'h0A, 32'hDDDDDDDD, 1'b0);
    expResp("R10 fill alloc", 1'b1, 1'b0, 1'b0, 32'h0);
    issue(3'd4, 8'h0E, 32'hEEEEEEEE, 1'b0);
    chk("R5 dirty evict addr", {24'b0, gWbA}, 32'h06);
    chk("R5 dirty evict data", gWbD, 32'hCCCCCCCC);
    issue(3'd4, 8'h12, 32'hF0F0F0F0, 1'b0);
    chk("R10 clean fill not written back", {31'b0, gWbV}, 32'd0);
    expResp("R3 clean victim", 1'b1, 1'b1, 1'b0, 32'h0);

    // R11 reset invalidates everything
    rst_n = 1'b0;
    @(negedge clk); #1;
    chk("R11 respValid in reset", {31'b0, respValid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    issue(3'd0, 8'h0D, 32'h0, 1'b0);
    expResp("R11 invalid after reset", 1'b0, 1'b0, 1'b1, 32'h0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog R11 actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

endmodule